// File: doc/BRIEF.md
# Indirect PHY Delay Register Access Port

This block gives a host a path to a small bank of 8-bit PHY delay settings without mapping each setting into the host address space. One 32-bit command/status word sits in a 1 KiB register window. The host places a PHY register address and a byte of write data into that word and then raises a request bit. The block runs the access on its local delay register bank, which models a configurable access latency. It then raises an acknowledge bit and, for reads, returns the byte in the same word.

The exchange is a four-phase handshake. The host raises a request, the block raises the acknowledge, the host drops the request, and the block drops the acknowledge. The bank holds per-speed-mode input delay settings at PHY addresses 0x00 to 0x08. It holds clock and strobe delay-locked-loop delays at 0x0B, 0x0C and 0x0D. Every other PHY address has no storage behind it, but a request to it still completes the handshake. The acknowledge comes back within a few cycles, well inside the roughly 10 µs that host software waits before it gives up.

Top module: `phy_access_port`

## Requirements
- R1: A synchronous reset clears the command word (it reads 0x00000000) and every PHY delay register (each reads back 0).
- R2: The command word sits at byte offset 0x010. PHY address is bits 7:0, write data bits 15:8, read data bits 23:16, write request bit 24, read request bit 25, acknowledge bit 26, and bits 31:27 always read 0. A host write sets only bits 7:0, 15:8, 24 and 25. The values written to bits 23:16, 26 and 31:27 have no effect.
- R3: After a request bit is set, the acknowledge bit rises once the bank access has finished. It stays 1 while the request that started the access is still 1. It returns to 0 after the host clears that request.
- R4: For a read, bits 23:16 hold the addressed register value by the time the acknowledge bit reads 1. They keep that value until the next read completes.
- R5: The acknowledge bit becomes visible at most ACC_LAT+4 bus-read polls after the host write that sets a request, where one poll is one bus read cycle.
- R6: PHY addresses 0x00–0x08 and 0x0B–0x0D each store an 8-bit value. A write there can be read back unchanged.
- R7: A request to any other PHY address still completes the handshake. A write to such an address changes nothing, and a read returns 0.
- R8: If both request bits are 1 together, the write runs first. The acknowledge falls only when the write request is cleared. A read request still held at that point then runs as its own handshake.
- R9: Changes to the address, data or request fields made while a handshake is running do not alter the access in progress.
- R10: Reads of any window offset other than the command word return 0. Host writes to such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Host access strobe, one cycle per access |
| bus_we | input | 1 | 1 = host write, 0 = host read |
| bus_addr | input | BUS_AW | Byte offset within the register window |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Registered host read data, valid the cycle after a read strobe |

## Verification
The bench goes after the handshake edges. If the acknowledge dropped while the request was still high, the host would see the acknowledge flicker. If the read byte were loaded after the acknowledge, the host would capture stale data. The bench sets both request bits together. A design that gave the read priority would return the old register value and leave the new byte unwritten. The bench also rewrites the address and data while an access is running, which a design that did not latch its operands would act on. It sweeps unimplemented addresses, including ones beyond the bank. A bank that aliased or stored those addresses would return a nonzero value where 0 is expected.

// File: rtl/phy_port_pkg.sv
package phy_port_pkg;

  // Command word field positions (the host software decodes these)
  localparam int unsigned F_ADDR_LSB  = 0;
  localparam int unsigned F_WDAT_LSB  = 8;
  localparam int unsigned F_RDAT_LSB  = 16;
  localparam int unsigned F_WREQ_BIT  = 24;
  localparam int unsigned F_RREQ_BIT  = 25;
  localparam int unsigned F_ACK_BIT   = 26;
  localparam int unsigned PHY_AW      = 8;
  localparam int unsigned PHY_DW      = 8;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_BUSY = 2'd1,
    HS_ACK  = 2'd2
  } hs_state_e;

  // Delay slots that carry storage: mode input delays and DLL delays
  function automatic logic slot_present(input logic [31:0] a);
    return (a <= 32'h08) || ((a >= 32'h0B) && (a <= 32'h0D));
  endfunction

endpackage

// File: rtl/port_host_regs.sv
module port_host_regs
  import phy_port_pkg::*;
#(
  parameter int unsigned BUS_AW     = 10,
  parameter logic [BUS_AW-1:0] CMD_OFFSET = 'h010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [PHY_DW-1:0] rd_field,
  input  logic              ack_bit,
  output logic [31:0]       bus_rdata,
  output logic [PHY_AW-1:0] cmd_addr,
  output logic [PHY_DW-1:0] cmd_wdata,
  output logic              wr_req,
  output logic              rd_req
);

  logic        hit;
  logic [31:0] word_view;

  assign hit = (bus_addr == CMD_OFFSET);

  always_comb begin
    word_view = '0;
    word_view[F_ADDR_LSB +: PHY_AW] = cmd_addr;
    word_view[F_WDAT_LSB +: PHY_DW] = cmd_wdata;
    word_view[F_RDAT_LSB +: PHY_DW] = rd_field;
    word_view[F_WREQ_BIT]           = wr_req;
    word_view[F_RREQ_BIT]           = rd_req;
    word_view[F_ACK_BIT]            = ack_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_addr  <= '0;
      cmd_wdata <= '0;
      wr_req    <= 1'b0;
      rd_req    <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (bus_en && bus_we && hit) begin
        cmd_addr  <= bus_wdata[F_ADDR_LSB +: PHY_AW];
        cmd_wdata <= bus_wdata[F_WDAT_LSB +: PHY_DW];
        wr_req    <= bus_wdata[F_WREQ_BIT];
        rd_req    <= bus_wdata[F_RREQ_BIT];
      end
      if (bus_en && !bus_we && hit) bus_rdata <= word_view;
      else                          bus_rdata <= '0;
    end
  end

  // R10: offsets other than the command word read as zero
  a_r10_other_offset_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_we && !hit) |=> (bus_rdata == 32'h0));

  // R2: top bits of the returned word are never set
  a_r2_upper_bits_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata[31:27] == 5'b0));

  // R10: host writes elsewhere leave the command fields alone
  a_r10_foreign_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we && !hit) |=> ($stable(cmd_addr) && $stable(cmd_wdata)
                                    && $stable(wr_req) && $stable(rd_req)));

endmodule

// File: rtl/port_handshake.sv
module port_handshake
  import phy_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic [PHY_AW-1:0] cmd_addr,
  input  logic [PHY_DW-1:0] cmd_wdata,
  input  logic              bank_done,
  input  logic [PHY_DW-1:0] bank_rdata,
  output logic              start,
  output logic              op_wr,
  output logic [PHY_AW-1:0] op_addr,
  output logic [PHY_DW-1:0] op_wdata,
  output logic              ack,
  output logic [PHY_DW-1:0] rd_field
);

  hs_state_e state;
  logic      owner_req;

  // The request that opened the handshake decides when it closes
  assign owner_req = op_wr ? wr_req : rd_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= HS_IDLE;
      start    <= 1'b0;
      op_wr    <= 1'b0;
      op_addr  <= '0;
      op_wdata <= '0;
      ack      <= 1'b0;
      rd_field <= '0;
    end else begin
      start <= 1'b0;
      unique case (state)
        HS_IDLE: begin
          if (wr_req || rd_req) begin
            start    <= 1'b1;
            op_wr    <= wr_req;       // write wins when both are set
            op_addr  <= cmd_addr;
            op_wdata <= cmd_wdata;
            state    <= HS_BUSY;
          end
        end
        HS_BUSY: begin
          if (bank_done) begin
            ack <= 1'b1;
            if (!op_wr) rd_field <= bank_rdata;
            state <= HS_ACK;
          end
        end
        HS_ACK: begin
          if (!owner_req) begin
            ack   <= 1'b0;
            state <= HS_IDLE;
          end
        end
        default: state <= HS_IDLE;
      endcase
    end
  end

  // R3: acknowledge holds while the owning request is still up
  a_r3_ack_holds: assert property (@(posedge clk) disable iff (rst)
    (ack && owner_req) |=> ack);

  // R3: acknowledge only rises after the bank reports completion
  a_r3_ack_after_done: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(bank_done));

  // R4: read byte only moves on the cycle after a completion
  a_r4_rdata_stable: assert property (@(posedge clk) disable iff (rst)
    !$past(bank_done) |-> $stable(rd_field));

  // R9: a new access never launches while acknowledge is up
  a_r9_no_start_in_ack: assert property (@(posedge clk) disable iff (rst)
    start |-> !ack);

  // R9: captured operands stay fixed until acknowledge falls
  a_r9_operands_frozen: assert property (@(posedge clk) disable iff (rst)
    (state != HS_IDLE && !start) |=> ($stable(op_addr) && $stable(op_wdata)
                                      && $stable(op_wr)));

endmodule

// File: rtl/phy_delay_bank.sv
module phy_delay_bank
  import phy_port_pkg::*;
#(
  parameter int unsigned ACC_LAT = 4,
  parameter int unsigned DEPTH   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              op_wr,
  input  logic [PHY_AW-1:0] op_addr,
  input  logic [PHY_DW-1:0] op_wdata,
  output logic              done,
  output logic [PHY_DW-1:0] rdata
);

  localparam int unsigned CW = (ACC_LAT > 1) ? $clog2(ACC_LAT) : 1;
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(ACC_LAT - 1);

  logic              busy;
  logic [CW-1:0]     cnt;
  logic              fire;
  logic              in_range;
  logic              present;
  logic [IW-1:0]     idx;
  logic [PHY_DW-1:0] slot_q [DEPTH];
  logic [PHY_DW-1:0] sel_val;

  assign fire     = busy && (cnt == '0);
  assign in_range = ({24'd0, op_addr} < DEPTH);
  assign present  = in_range && slot_present({24'd0, op_addr});
  assign idx      = op_addr[IW-1:0];
  assign sel_val  = in_range ? slot_q[idx] : '0;

  // One storage byte per implemented slot; the rest are tied to zero
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    if (slot_present(32'(g))) begin : g_store
      always_ff @(posedge clk) begin
        if (rst)                                  slot_q[g] <= '0;
        else if (fire && op_wr && present && idx == IW'(g)) slot_q[g] <= op_wdata;
      end
    end else begin : g_empty
      assign slot_q[g] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= CNT_LOAD;
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (!op_wr) rdata <= sel_val;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R3: completion is a single-cycle pulse
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: reads of slots without storage return zero
  a_r7_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    (fire && !op_wr && !present) |=> (rdata == '0));

  // R9: a start never lands on an access already counting
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

  initial begin
    assert (ACC_LAT >= 1) else $error("ACC_LAT must be at least 1");
    assert (DEPTH >= 14)  else $error("DEPTH must cover slot 0x0D");
  end

endmodule

// File: rtl/phy_access_port.sv
module phy_access_port
  import phy_port_pkg::*;
#(
  parameter int unsigned BUS_AW     = 10,
  parameter logic [BUS_AW-1:0] CMD_OFFSET = 'h010,
  parameter int unsigned ACC_LAT    = 4,
  parameter int unsigned DEPTH      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);

  logic [PHY_AW-1:0] cmd_addr;
  logic [PHY_DW-1:0] cmd_wdata;
  logic              wr_req;
  logic              rd_req;
  logic              start;
  logic              op_wr;
  logic [PHY_AW-1:0] op_addr;
  logic [PHY_DW-1:0] op_wdata;
  logic              ack;
  logic [PHY_DW-1:0] rd_field;
  logic              bank_done;
  logic [PHY_DW-1:0] bank_rdata;

  port_host_regs #(.BUS_AW(BUS_AW), .CMD_OFFSET(CMD_OFFSET)) u_host (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_field(rd_field),
    .ack_bit(ack), .bus_rdata(bus_rdata), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .wr_req(wr_req), .rd_req(rd_req)
  );

  port_handshake u_hs (
    .clk(clk), .rst(rst), .wr_req(wr_req), .rd_req(rd_req),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .bank_done(bank_done),
    .bank_rdata(bank_rdata), .start(start), .op_wr(op_wr),
    .op_addr(op_addr), .op_wdata(op_wdata), .ack(ack), .rd_field(rd_field)
  );

  phy_delay_bank #(.ACC_LAT(ACC_LAT), .DEPTH(DEPTH)) u_bank (
    .clk(clk), .rst(rst), .start(start), .op_wr(op_wr), .op_addr(op_addr),
    .op_wdata(op_wdata), .done(bank_done), .rdata(bank_rdata)
  );

  // R8: with both requests up at launch, the write is the one taken
  a_r8_write_first: assert property (@(posedge clk) disable iff (rst)
    (start && $past(wr_req)) |-> op_wr);

  // R1: nothing is acknowledged without a request having been seen
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(u_hs.state != HS_IDLE));

endmodule

// File: tb/tb_phy_access_port.sv
module tb_phy_access_port;

  localparam int CLK_PERIOD = 10;
  localparam int ACC_LAT    = 4;
  localparam int BUS_AW     = 10;
  localparam logic [BUS_AW-1:0] CMD = 10'h010;
  localparam int POLL_MAX   = 64;

  // {phy address, data} written in order, then read back
  localparam logic [15:0] VEC [16] = '{
    16'h0011, 16'h0122, 16'h0233, 16'h0344, 16'h0455, 16'h0566,
    16'h0677, 16'h0788, 16'h0899, 16'h09AA, 16'h0ABB, 16'h0BC1,
    16'h0CC2, 16'h0DC3, 16'h0EDE, 16'h3FF0
  };

  logic              clk = 1'b0;
  logic              rst;
  logic              bus_en;
  logic              bus_we;
  logic [BUS_AW-1:0] bus_addr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;

  int checks   = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_access_port #(.BUS_AW(BUS_AW), .CMD_OFFSET(CMD), .ACC_LAT(ACC_LAT)) dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic has_slot(input logic [7:0] a);
    return (a <= 8'h08) || (a >= 8'h0B && a <= 8'h0D);
  endfunction

  task automatic chk(input logic ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [BUS_AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [BUS_AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_ack(input logic lvl, output int n, output logic [31:0] w);
    n = 0;
    do begin
      bus_rd(CMD, w);
      n++;
    end while (w[26] !== lvl && n < POLL_MAX);
  endtask

  task automatic phy_op(input logic wr, input logic [7:0] a, input logic [7:0] d,
                        output logic [7:0] rv, output int lat);
    logic [31:0] base, w;
    int n;
    base = {16'h0000, d, a};
    bus_wr(CMD, base);
    bus_wr(CMD, base | (wr ? 32'h0100_0000 : 32'h0200_0000));
    wait_ack(1'b1, lat, w);
    chk(w[26] === 1'b1, "R3 ack rises", {31'd0, w[26]}, 32'd1);
    rv = w[23:16];
    bus_wr(CMD, base);
    wait_ack(1'b0, n, w);
    chk(w[26] === 1'b0, "R3 ack falls after clear", {31'd0, w[26]}, 32'd0);
  endtask

  task automatic do_reset();
    rst = 1'b1; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog all-reqs actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic [7:0]  rv;
    int lat;

    do_reset();

    // R1: command word and every slot clear after reset
    bus_rd(CMD, w);
    chk(w == 32'h0, "R1 word after reset", w, 32'h0);
    for (int i = 0; i < 16; i++) begin
      phy_op(1'b0, 8'(i), 8'h00, rv, lat);
      chk(rv == 8'h00, "R1 slot after reset", {24'd0, rv}, 32'h0);
    end

    // R2: field layout, read-only bits ignored (read byte is 0 from last read)
    bus_wr(CMD, 32'hFCFF_3C5A);
    bus_rd(CMD, w);
    chk(w == 32'h0000_3C5A, "R2 field readback", w, 32'h0000_3C5A);
    bus_wr(CMD, 32'h0);

    // R6/R7/R5: table of writes, each acknowledged within the bound
    for (int i = 0; i < 16; i++) begin
      phy_op(1'b1, VEC[i][15:8], VEC[i][7:0], rv, lat);
      chk(lat <= ACC_LAT + 4, "R5 write ack latency", lat, ACC_LAT + 4);
    end
    for (int i = 0; i < 16; i++) begin
      logic [7:0] exp;
      exp = has_slot(VEC[i][15:8]) ? VEC[i][7:0] : 8'h00;
      phy_op(1'b0, VEC[i][15:8], 8'h00, rv, lat);
      chk(lat <= ACC_LAT + 4, "R5 read ack latency", lat, ACC_LAT + 4);
      chk(rv == exp, has_slot(VEC[i][15:8]) ? "R6 slot readback" : "R7 empty slot reads 0",
          {24'd0, rv}, {24'd0, exp});
    end

    // R4: read byte held across a later write
    phy_op(1'b0, 8'h0C, 8'h00, rv, lat);
    phy_op(1'b1, 8'h01, 8'h7E, rv, lat);
    bus_rd(CMD, w);
    chk(w[23:16] == 8'hC2, "R4 read byte held", {24'd0, w[23:16]}, 32'hC2);

    // R8: both requests set; write first, then held read runs
    bus_wr(CMD, 32'h0000_5A05);
    bus_wr(CMD, 32'h0300_5A05);
    wait_ack(1'b1, lat, w);
    chk(w[26] === 1'b1, "R8 first ack", {31'd0, w[26]}, 32'd1);
    bus_wr(CMD, 32'h0200_5A05);
    wait_ack(1'b0, lat, w);
    chk(w[26] === 1'b0, "R8 ack drops on write clear", {31'd0, w[26]}, 32'd0);
    wait_ack(1'b1, lat, w);
    chk(w[23:16] == 8'h5A, "R8 write went first", {24'd0, w[23:16]}, 32'h5A);
    bus_wr(CMD, 32'h0000_5A05);
    wait_ack(1'b0, lat, w);

    // R9: operands rewritten mid-access are not used
    bus_wr(CMD, 32'h0000_5502);
    bus_wr(CMD, 32'h0100_5502);
    bus_wr(CMD, 32'h0100_9903);
    wait_ack(1'b1, lat, w);
    bus_wr(CMD, 32'h0000_9903);
    wait_ack(1'b0, lat, w);
    phy_op(1'b0, 8'h02, 8'h00, rv, lat);
    chk(rv == 8'h55, "R9 launched access kept", {24'd0, rv}, 32'h55);
    phy_op(1'b0, 8'h03, 8'h00, rv, lat);
    chk(rv == 8'h44, "R9 late operands ignored", {24'd0, rv}, 32'h44);

    // R10: other offsets in the window
    bus_wr(CMD, 32'h0000_1234);
    bus_wr(10'h200, 32'hFFFF_FFFF);
    bus_rd(10'h200, w);
    chk(w == 32'h0, "R10 other offset reads 0", w, 32'h0);
    bus_rd(CMD, w);
    chk(w[15:0] == 16'h1234 && w[25:24] == 2'b00, "R10 foreign write ignored",
        w, {w[31:16], 16'h1234});

    // R1: reset again after activity
    do_reset();
    bus_rd(CMD, w);
    chk(w == 32'h0, "R1 word after second reset", w, 32'h0);
    phy_op(1'b0, 8'h0B, 8'h00, rv, lat);
    chk(rv == 8'h00, "R1 slot cleared by reset", {24'd0, rv}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule